// File: doc/BRIEF.md
# Load-Align Shift-Insert Unit

This unit assembles a 64-bit value from a stream of narrow memory elements. A byte or halfword arrives already extracted and right-justified. The unit then moves the current contents of a 64-bit destination toward the least significant end by the width of that element. The new element is written into the top of the destination. Because the newest element always lands at the top, a run of loads from consecutive addresses builds a little-endian word in arrival order, much like a small FIFO.

The caller supplies the old destination value on every accepted load, because the destination is both read and written. The unit registers the merged result and keeps it stable between loads. For one cycle after each accepted load it also presents the result on a write-back strobe, so that a register file can take it. The unit does not generate addresses, access memory or arbitrate register-file ports.

Top module: `lalign_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_value` becomes zero and `wb_valid` becomes low in the following cycle.
- R2: With `ld_valid` high and `ld_size` = 0 (byte), after the edge `res_value[63:56]` equals `ld_data[7:0]` and `res_value[55:0]` equals `ld_old[63:8]`.
- R3: With `ld_valid` high and `ld_size` = 1 (halfword), after the edge `res_value[63:48]` equals `ld_data[15:0]` and `res_value[47:0]` equals `ld_old[63:16]`.
- R4: In byte mode, `ld_data[15:8]` has no effect on the result.
- R5: While `ld_valid` is low, `res_value` holds its value, whatever `ld_old`, `ld_data` and `ld_size` do.
- R6: `wb_valid` is high for exactly the cycle that follows each accepted load, and `wb_value` then equals `res_value`.
- R7: When each result is fed back as the next old value, starting from all ones, the byte loads 01, 02, 03, 04 give 0x04030201FFFFFFFF. Four halfword loads of 0x0201, 0x0403, 0x0605, 0x0807 give 0x0807060504030201.
- R8: The inserted element is neither sign- nor zero-extended: an element with its top bit set appears unchanged, and the bits shifted out of the low end are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load accepted this cycle |
| ld_size | input | 1 | Element size: 0 = byte, 1 = halfword |
| ld_old | input | 64 | Current destination value |
| ld_data | input | 16 | Loaded element, right-justified |
| res_value | output | 64 | Registered merged result |
| wb_valid | output | 1 | Write-back strobe, one cycle per load |
| wb_value | output | 64 | Write-back data |

## Verification
The bench applies single byte and halfword loads over an old value with distinct bytes, so that any misplaced lane or wrong shift distance shows up. It applies byte loads that carry garbage in the upper data byte, which separates correct byte masking from halfword behaviour. Chained runs that start from all ones, with each result fed back, confirm FIFO ordering and that old bytes drop out at the bottom. Elements with the top bit set, idle cycles with churning inputs, and back-to-back loads then separate a correct design from sign extension, leaking updates and write-back strobes that are missing or held too long.

// File: rtl/lalign_pkg.sv
package lalign_pkg;

    localparam int unsigned LA_DATA_W = 64;
    localparam int unsigned LA_ELEM_W = 8;
    localparam int unsigned LA_HALF_W = 2 * LA_ELEM_W;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } elem_size_e;

    typedef logic [LA_DATA_W-1:0] word_t;
    typedef logic [LA_HALF_W-1:0] elem_t;

    typedef struct packed {
        elem_size_e size;
        elem_t      data;
        word_t      old;
    } ld_req_t;

endpackage

// File: rtl/lalign_merge.sv
module lalign_merge
    import lalign_pkg::*;
(
    input  ld_req_t req,
    output word_t   merged
);
    localparam int unsigned B_W = LA_ELEM_W;
    localparam int unsigned H_W = LA_HALF_W;

    word_t byte_cand;
    word_t half_cand;

    always_comb begin
        byte_cand = {req.data[B_W-1:0], req.old[LA_DATA_W-1:B_W]};
        half_cand = {req.data[H_W-1:0], req.old[LA_DATA_W-1:H_W]};
    end

    always_comb begin
        unique case (req.size)
            SZ_BYTE: merged = byte_cand;
            SZ_HALF: merged = half_cand;
            default: merged = byte_cand;
        endcase
    end

endmodule

// File: rtl/lalign_hold_reg.sv
module lalign_hold_reg
    import lalign_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t d,
    output word_t q,
    output logic  wb_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            wb_stb <= 1'b0;
        end else begin
            wb_stb <= load;
            if (load) q <= d;
        end
    end

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    // R6
    strobe_follows_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> wb_stb);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> !wb_stb);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (q == '0) && !wb_stb);

endmodule

// File: rtl/lalign_unit.sv
module lalign_unit
    import lalign_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_valid,
    input  logic                 ld_size,
    input  logic [LA_DATA_W-1:0] ld_old,
    input  logic [LA_HALF_W-1:0] ld_data,
    output logic [LA_DATA_W-1:0] res_value,
    output logic                 wb_valid,
    output logic [LA_DATA_W-1:0] wb_value
);
    localparam int unsigned B_W = LA_ELEM_W;
    localparam int unsigned H_W = LA_HALF_W;

    ld_req_t req;
    word_t   merged;
    word_t   res_q;
    logic    stb_q;

    always_comb begin
        req.size = elem_size_e'(ld_size);
        req.data = ld_data;
        req.old  = ld_old;
    end

    lalign_merge merge_i (
        .req    (req),
        .merged (merged)
    );

    lalign_hold_reg reg_i (
        .clk    (clk),
        .rst    (rst),
        .load   (ld_valid),
        .d      (merged),
        .q      (res_q),
        .wb_stb (stb_q)
    );

    assign res_value = res_q;
    assign wb_valid  = stb_q;
    assign wb_value  = res_q;

    // R2
    byte_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_size) |=>
            (res_value[LA_DATA_W-1 -: B_W] == $past(ld_data[B_W-1:0])) &&
            (res_value[LA_DATA_W-B_W-1:0] == $past(ld_old[LA_DATA_W-1:B_W])));

    // R3
    half_insert_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_size) |=>
            (res_value[LA_DATA_W-1 -: H_W] == $past(ld_data)) &&
            (res_value[LA_DATA_W-H_W-1:0] == $past(ld_old[LA_DATA_W-1:H_W])));

    // R6
    wb_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (wb_value == res_value));

endmodule

// File: tb/lalign_unit_tb_top.sv
module lalign_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_valid;
    logic        ld_size;
    logic [63:0] ld_old;
    logic [15:0] ld_data;
    logic [63:0] res_value;
    logic        wb_valid;
    logic [63:0] wb_value;

    int nvec = 0;
    int nerr = 0;
    logic [63:0] expq[$];
    logic [63:0] last;
    bit done = 0;

    always #2 clk = ~clk;

    lalign_unit dut_i (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_size(ld_size),
        .ld_old(ld_old), .ld_data(ld_data), .res_value(res_value),
        .wb_valid(wb_valid), .wb_value(wb_value)
    );

    function automatic logic [63:0] model(logic [63:0] o, logic [15:0] d, logic sz);
        if (sz) return {d, o[63:16]};
        return {d[7:0], o[63:8]};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver: one load per call, expected result pushed to scoreboard
    task automatic load(logic sz, logic [15:0] d, logic [63:0] o);
        @(negedge clk);
        ld_valid = 1'b1; ld_size = sz; ld_data = d; ld_old = o;
        last = model(o, d, sz);
        expq.push_back(last);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld_valid = 1'b0;
            ld_size  = ~ld_size;
            ld_old   = {ld_old[31:0], ld_old[63:32]} ^ 64'h5a5a_1234_dead_beef;
            ld_data  = ld_data + 16'h1357;
        end
    endtask

    // monitor: compares write-back against scoreboard (R6)
    always @(negedge clk) begin
        if (!rst && !done && wb_valid) begin
            if (expq.size() == 0) begin
                nvec++; nerr++;
                $display("FAIL R6: actual wb_valid 1 expected 0 (no load pending)");
            end else begin
                logic [63:0] e;
                e = expq.pop_front();
                check("R6 wb_value", wb_value, e);
                check("R2/R3 res_value", res_value, e);
            end
        end
    end

    initial begin
        #(4 * 100000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        logic [63:0] acc;
        rst = 1'b1; ld_valid = 0; ld_size = 0; ld_old = '1; ld_data = '1;
        repeat (3) @(negedge clk);
        check("R1 res_value", res_value, 64'h0);
        check("R1 wb_valid", {63'h0, wb_valid}, 64'h0);
        rst = 1'b0;

        // R2 byte insert
        load(1'b0, 16'h00a5, 64'h1122334455667788);
        idle(1);
        check("R2", res_value, 64'ha511223344556677);
        // R3 halfword insert
        load(1'b1, 16'hbeef, 64'h1122334455667788);
        idle(1);
        check("R3", res_value, 64'hbeef112233445566);
        // R4 upper data byte ignored in byte mode
        load(1'b0, 16'hff3c, 64'h0102030405060708);
        idle(1);
        check("R4", res_value, 64'h3c01020304050607);
        // R5 hold while idle with churning inputs
        idle(5);
        check("R5 hold", res_value, 64'h3c01020304050607);
        check("R5 no strobe", {63'h0, wb_valid}, 64'h0);
        // R8 no extension
        load(1'b0, 16'h0080, 64'h0);
        idle(1);
        check("R8 byte", res_value, 64'h8000000000000000);
        load(1'b1, 16'h8001, 64'h00000000000000ff);
        idle(1);
        check("R8 half", res_value, 64'h8001000000000000);

        // R7 byte chain, back to back
        acc = '1;
        for (int i = 1; i <= 4; i++) begin
            load(1'b0, 16'(i), acc);
            acc = last;
        end
        idle(1);
        check("R7 byte chain", res_value, 64'h04030201ffffffff);
        // R7 halfword chain
        acc = '1;
        for (int i = 0; i < 4; i++) begin
            load(1'b1, {8'(2*i+2), 8'(2*i+1)}, acc);
            acc = last;
        end
        idle(1);
        check("R7 half chain", res_value, 64'h0807060504030201);
        idle(2);

        // R1 reset mid-stream
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check("R1 after reset", res_value, 64'h0);
        rst = 1'b0;
        idle(1);
        check("R6 queue drained", 64'(expq.size()), 64'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule